// File: doc/BRIEF.md
# Coprocessor Control, Status and Semaphore Registers

This block is the host-visible control and status register file of a small coprocessor. A host reaches it through a single-cycle 32-bit register port made up of request, write enable, word address, write data and read data. The block keeps the coprocessor's halt, broke, single-step and interrupt-on-break flags and eight general signal flags. It drives an interrupt request toward the host's interrupt controller, holds a one-bit hardware semaphore, and passes host writes of the program counter through to the coprocessor only while the coprocessor is halted.

The host never writes a flag directly. A write to the status word carries a separate set bit and a separate clear bit for each flag. A lone set bit sets the flag, a lone clear bit clears it, and both bits together leave it as it was. The coprocessor reports a break with a one-cycle pulse on `break_i`. A semaphore read returns the current value and claims the semaphore in the same access. Any write to the semaphore releases it.

Top module: `cps_status_regs`

## Requirements
- R1: After reset `halt_o` is 1. `broke_o`, `irq_o`, `sstep_o`, `intr_break_en_o`, `signal_o`, `pc_we_o` and `steps_clr_o` are 0, the semaphore is free, and the status word reads 0x1.
- R2: In a status write (word 4), bit 0 alone clears halt. Bit 1 alone sets halt and pulses `steps_clr_o` for one cycle. Bits 0 and 1 together leave halt and `steps_clr_o` unchanged.
- R3: Status write bit 2 clears broke, whatever else the word holds. No status write can set broke.
- R4: Status write bit 4 alone raises `irq_o` and bit 3 alone lowers it. Both bits together leave it unchanged.
- R5: Single-step uses clear bit 5 and set bit 6, and interrupt-on-break uses clear bit 7 and set bit 8. Signal n uses clear bit 9+2n and set bit 10+2n. Each pair follows the rule of R4.
- R6: The status word (word 4) reads halt at bit 0, broke at 1, `dma_busy_i` at 2, `dma_full_i` at 3, single-step at 5, interrupt-on-break at 6 and signal n at 7+n. All other bits read 0.
- R7: A read of word 7 returns the semaphore in bit 0 (1 = taken) and leaves it taken. Any write to word 7 frees it.
- R8: A write to word 8 pulses `pc_we_o` in the next cycle, with `pc_wdata_o` set to write data bits 11:2 and bits 1:0 zero. This happens only if halt was set when the write was accepted; otherwise `pc_we_o` stays 0.
- R9: A read of word 8 returns `pc_i` with bits 1:0 forced to zero.
- R10: Word 5 reads `dma_full_i` in bit 0. Word 6 and every unmapped word read 0.
- R11: A `break_i` pulse sets broke and halt. It raises `irq_o` only if interrupt-on-break is set. In the same cycle it overrides any host command that would clear these flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Register word index |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| break_i | input | 1 | Break pulse from the coprocessor |
| dma_busy_i | input | 1 | DMA busy, reported in status |
| dma_full_i | input | 1 | DMA request queue full |
| pc_i | input | PC_W | Coprocessor program counter |
| pc_we_o | output | 1 | Gated program counter write strobe |
| pc_wdata_o | output | PC_W | Program counter write value |
| steps_clr_o | output | 1 | Step counter reset pulse |
| halt_o | output | 1 | Halt flag |
| broke_o | output | 1 | Broke flag |
| sstep_o | output | 1 | Single-step flag |
| intr_break_en_o | output | 1 | Interrupt-on-break flag |
| signal_o | output | 8 | General signal flags |
| irq_o | output | 1 | Interrupt request to the host |

## Verification
Read data is combinational. The bench therefore samples it one time unit after it drives a read at a falling edge, before the rising edge where the semaphore claim takes effect. Every flag, `irq_o`, `steps_clr_o` and `pc_we_o` changes at the first rising edge after the access or break pulse. The bench samples them at the next falling edge, which is the only point where the one-cycle pulses can be seen. To check that a command pair left a flag unchanged, the bench compares the flag with its value before the write, after that same edge.

// File: rtl/cps_pkg.sv
package cps_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_SIG   = 8;

  // flag vector slots
  localparam int FL_HALT   = 0;
  localparam int FL_BROKE  = 1;
  localparam int FL_INTR   = 2;
  localparam int FL_SSTEP  = 3;
  localparam int FL_IOB    = 4;
  localparam int FL_SIG0   = 5;
  localparam int NUM_FLAGS = FL_SIG0 + NUM_SIG;

  // status write command bits
  localparam int CMD_CLR_HALT  = 0;
  localparam int CMD_SET_HALT  = 1;
  localparam int CMD_CLR_BROKE = 2;
  localparam int CMD_CLR_INTR  = 3;
  localparam int CMD_SET_INTR  = 4;
  localparam int CMD_CLR_SSTEP = 5;
  localparam int CMD_SET_SSTEP = 6;
  localparam int CMD_CLR_IOB   = 7;
  localparam int CMD_SET_IOB   = 8;
  localparam int CMD_SIG_BASE  = 9;
  localparam int CMD_W         = CMD_SIG_BASE + 2 * NUM_SIG;

  // status read bits
  localparam int ST_HALT  = 0;
  localparam int ST_BROKE = 1;
  localparam int ST_BUSY  = 2;
  localparam int ST_FULL  = 3;
  localparam int ST_SSTEP = 5;
  localparam int ST_IOB   = 6;
  localparam int ST_SIG0  = 7;

  // register word indices
  localparam int REG_STATUS = 4;
  localparam int REG_FULL   = 5;
  localparam int REG_ZERO   = 6;
  localparam int REG_SEM    = 7;
  localparam int REG_PC     = 8;
endpackage

// File: rtl/cps_flag_cell.sv
module cps_flag_cell #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic force_i,
  output logic q_o
);
  logic q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (force_i)             q_d = 1'b1;
    else if (set_i && !clr_i) q_d = 1'b1;
    else if (clr_i && !set_i) q_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= RST_VAL;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/cps_cmd_decode.sv
module cps_cmd_decode
  import cps_pkg::*;
(
  input  logic                 wr_i,
  input  logic [CMD_W-1:0]     cmd_i,
  input  logic                 break_i,
  input  logic                 iob_i,
  output logic [NUM_FLAGS-1:0] set_o,
  output logic [NUM_FLAGS-1:0] clr_o,
  output logic [NUM_FLAGS-1:0] force_o,
  output logic                 steps_clr_o
);
  always_comb begin
    set_o   = '0;
    clr_o   = '0;
    force_o = '0;

    set_o[FL_HALT]   = wr_i & cmd_i[CMD_SET_HALT];
    clr_o[FL_HALT]   = wr_i & cmd_i[CMD_CLR_HALT];
    force_o[FL_HALT] = break_i;

    // broke has no host set path
    clr_o[FL_BROKE]   = wr_i & cmd_i[CMD_CLR_BROKE];
    force_o[FL_BROKE] = break_i;

    set_o[FL_INTR]   = wr_i & cmd_i[CMD_SET_INTR];
    clr_o[FL_INTR]   = wr_i & cmd_i[CMD_CLR_INTR];
    force_o[FL_INTR] = break_i & iob_i;

    set_o[FL_SSTEP] = wr_i & cmd_i[CMD_SET_SSTEP];
    clr_o[FL_SSTEP] = wr_i & cmd_i[CMD_CLR_SSTEP];

    set_o[FL_IOB] = wr_i & cmd_i[CMD_SET_IOB];
    clr_o[FL_IOB] = wr_i & cmd_i[CMD_CLR_IOB];

    for (int i = 0; i < NUM_SIG; i++) begin
      set_o[FL_SIG0+i] = wr_i & cmd_i[CMD_SIG_BASE+2*i+1];
      clr_o[FL_SIG0+i] = wr_i & cmd_i[CMD_SIG_BASE+2*i];
    end
  end

  assign steps_clr_o = wr_i & cmd_i[CMD_SET_HALT] & ~cmd_i[CMD_CLR_HALT];
endmodule

// File: rtl/cps_sem.sv
module cps_sem (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic claim_i,
  input  logic release_i,
  output logic taken_o
);
  logic taken_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        taken_q <= 1'b0;
    else if (release_i) taken_q <= 1'b0;
    else if (claim_i)   taken_q <= 1'b1;
  end

  assign taken_o = taken_q;
endmodule

// File: rtl/cps_rd_mux.sv
module cps_rd_mux
  import cps_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int PC_W   = 12
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  logic                 dma_busy_i,
  input  logic                 dma_full_i,
  input  logic                 sem_i,
  input  logic [PC_W-1:0]      pc_i,
  output logic [DATA_W-1:0]    rdata_o
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);
  localparam logic [ADDR_W-1:0] A_FULL   = ADDR_W'(REG_FULL);
  localparam logic [ADDR_W-1:0] A_SEM    = ADDR_W'(REG_SEM);
  localparam logic [ADDR_W-1:0] A_PC     = ADDR_W'(REG_PC);

  logic [DATA_W-1:0] status_w;
  logic              unused_pc_lsb;

  assign unused_pc_lsb = ^pc_i[1:0];

  always_comb begin
    status_w           = '0;
    status_w[ST_HALT]  = flags_i[FL_HALT];
    status_w[ST_BROKE] = flags_i[FL_BROKE];
    status_w[ST_BUSY]  = dma_busy_i;
    status_w[ST_FULL]  = dma_full_i;
    status_w[ST_SSTEP] = flags_i[FL_SSTEP];
    status_w[ST_IOB]   = flags_i[FL_IOB];
    for (int i = 0; i < NUM_SIG; i++) status_w[ST_SIG0+i] = flags_i[FL_SIG0+i];
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_STATUS: rdata_o = status_w;
      A_FULL:   rdata_o[0] = dma_full_i;
      A_SEM:    rdata_o[0] = sem_i;
      A_PC:     rdata_o[PC_W-1:0] = {pc_i[PC_W-1:2], 2'b00};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cps_status_regs.sv
module cps_status_regs
  import cps_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int PC_W     = 12,
  parameter bit HALT_RST = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic               break_i,
  input  logic               dma_busy_i,
  input  logic               dma_full_i,
  input  logic [PC_W-1:0]    pc_i,
  output logic               pc_we_o,
  output logic [PC_W-1:0]    pc_wdata_o,
  output logic               steps_clr_o,
  output logic               halt_o,
  output logic               broke_o,
  output logic               sstep_o,
  output logic               intr_break_en_o,
  output logic [NUM_SIG-1:0] signal_o,
  output logic               irq_o
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);
  localparam logic [ADDR_W-1:0] A_SEM    = ADDR_W'(REG_SEM);
  localparam logic [ADDR_W-1:0] A_PC     = ADDR_W'(REG_PC);

  logic                 wr_stat, rd_sem, wr_sem, wr_pc;
  logic [NUM_FLAGS-1:0] set_v, clr_v, force_v, flags;
  logic                 steps_clr_d, steps_clr_q;
  logic                 pc_we_q;
  logic [PC_W-1:0]      pc_wdata_q;
  logic                 sem_taken;
  logic                 unused_wdata;

  assign unused_wdata = ^wdata_i[31:CMD_W];

  assign wr_stat = req_i &  we_i & (addr_i == A_STATUS);
  assign rd_sem  = req_i & ~we_i & (addr_i == A_SEM);
  assign wr_sem  = req_i &  we_i & (addr_i == A_SEM);
  assign wr_pc   = req_i &  we_i & (addr_i == A_PC) & flags[FL_HALT];

  cps_cmd_decode u_dec (
    .wr_i        (wr_stat),
    .cmd_i       (wdata_i[CMD_W-1:0]),
    .break_i     (break_i),
    .iob_i       (flags[FL_IOB]),
    .set_o       (set_v),
    .clr_o       (clr_v),
    .force_o     (force_v),
    .steps_clr_o (steps_clr_d)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    localparam bit RV = (g == FL_HALT) ? HALT_RST : 1'b0;
    cps_flag_cell #(.RST_VAL(RV)) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (set_v[g]),
      .clr_i   (clr_v[g]),
      .force_i (force_v[g]),
      .q_o     (flags[g])
    );
  end

  cps_sem u_sem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .claim_i   (rd_sem),
    .release_i (wr_sem),
    .taken_o   (sem_taken)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      steps_clr_q <= 1'b0;
      pc_we_q     <= 1'b0;
      pc_wdata_q  <= '0;
    end else begin
      steps_clr_q <= steps_clr_d;
      pc_we_q     <= wr_pc;
      if (wr_pc) pc_wdata_q <= {wdata_i[PC_W-1:2], 2'b00};
    end
  end

  cps_rd_mux #(.ADDR_W(ADDR_W), .PC_W(PC_W)) u_rd (
    .addr_i     (addr_i),
    .flags_i    (flags),
    .dma_busy_i (dma_busy_i),
    .dma_full_i (dma_full_i),
    .sem_i      (sem_taken),
    .pc_i       (pc_i),
    .rdata_o    (rdata_o)
  );

  assign pc_we_o         = pc_we_q;
  assign pc_wdata_o      = pc_wdata_q;
  assign steps_clr_o     = steps_clr_q;
  assign halt_o          = flags[FL_HALT];
  assign broke_o         = flags[FL_BROKE];
  assign sstep_o         = flags[FL_SSTEP];
  assign intr_break_en_o = flags[FL_IOB];
  assign irq_o           = flags[FL_INTR];
  assign signal_o        = flags[FL_SIG0 +: NUM_SIG];
endmodule

// File: rtl/cps_status_regs_chk.sv
module cps_status_regs_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              break_i,
  input logic              halt_o,
  input logic              broke_o,
  input logic              irq_o,
  input logic              steps_clr_o,
  input logic              pc_we_o,
  input logic              intr_break_en_o
);
  logic wr_st, unused_chk;
  assign wr_st      = req_i && we_i && addr_i == ADDR_W'(4);
  assign unused_chk = ^wdata_i[31:5];

  assert_halt_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_st && wdata_i[0] && wdata_i[1] && !break_i) |=> $stable(halt_o));

  assert_halt_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_st && wdata_i[1] && !wdata_i[0]) |=> (halt_o && steps_clr_o));

  assert_no_host_broke_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !break_i |=> !$rose(broke_o));

  assert_irq_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past((wr_st && wdata_i[4] && !wdata_i[3]) || (break_i && intr_break_en_o)));

  assert_pc_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |-> $past(halt_o));

  assert_zero_word_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_W'(6)) |-> rdata_o == 32'd0);

  assert_break_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_i |=> (halt_o && broke_o));
endmodule

bind cps_status_regs cps_status_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_i           (req_i),
  .we_i            (we_i),
  .addr_i          (addr_i),
  .wdata_i         (wdata_i),
  .rdata_o         (rdata_o),
  .break_i         (break_i),
  .halt_o          (halt_o),
  .broke_o         (broke_o),
  .irq_o           (irq_o),
  .steps_clr_o     (steps_clr_o),
  .pc_we_o         (pc_we_o),
  .intr_break_en_o (intr_break_en_o)
);

// File: tb/cps_status_regs_test.sv
module cps_status_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] W_STATUS = 4'd4, W_FULL = 4'd5, W_ZERO = 4'd6,
                         W_SEM = 4'd7, W_PC = 4'd8;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0, brk = 1'b0, busy = 1'b0, full = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [11:0] pc = '0, pc_wdata;
  logic        pc_we, steps_clr, halt, broke, sstep, iob, irq;
  logic [7:0]  sig;
  int          n_vec = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cps_status_regs uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .break_i(brk), .dma_busy_i(busy),
    .dma_full_i(full), .pc_i(pc), .pc_we_o(pc_we), .pc_wdata_o(pc_wdata),
    .steps_clr_o(steps_clr), .halt_o(halt), .broke_o(broke), .sstep_o(sstep),
    .intr_break_en_o(iob), .signal_o(sig), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic host_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic pulse_break(input logic with_wr, input logic [31:0] d);
    @(negedge clk); brk = 1'b1;
    if (with_wr) begin req = 1'b1; we = 1'b1; addr = W_STATUS; wdata = d; end
    @(negedge clk); brk = 1'b0; req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic t_reset();
    logic [31:0] r;
    check("R1 halt", halt, 1); check("R1 broke", broke, 0);
    check("R1 irq", irq, 0);   check("R1 sstep", sstep, 0);
    check("R1 iob", iob, 0);   check("R1 signals", sig, 0);
    check("R1 pc_we", pc_we, 0); check("R1 steps_clr", steps_clr, 0);
    host_rd(W_STATUS, r); check("R1 status word", r, 32'h1);
    host_rd(W_SEM, r);    check("R1 sem free", r, 0);
  endtask

  task automatic t_sem();
    logic [31:0] r;
    host_rd(W_SEM, r); check("R7 taken after read", r, 1);
    host_rd(W_SEM, r); check("R7 stays taken", r, 1);
    host_wr(W_SEM, 32'hDEAD);
    host_rd(W_SEM, r); check("R7 released by write", r, 0);
    host_rd(W_SEM, r); check("R7 reclaimed", r, 1);
    host_wr(W_SEM, 32'h0);
  endtask

  task automatic t_halt();
    logic [31:0] r;
    host_wr(W_STATUS, 32'h1); check("R2 clear halt", halt, 0); check("R2 no step clr", steps_clr, 0);
    host_wr(W_STATUS, 32'h3); check("R2 both keep 0", halt, 0);
    host_wr(W_STATUS, 32'h2); check("R2 set halt", halt, 1); check("R2 step clr pulse", steps_clr, 1);
    host_wr(W_STATUS, 32'h3); check("R2 both keep 1", halt, 1); check("R2 both no pulse", steps_clr, 0);
    host_rd(W_STATUS, r); check("R6 status halted", r, 32'h1);
  endtask

  task automatic t_intr();
    host_wr(W_STATUS, 32'h10); check("R4 raise", irq, 1);
    host_wr(W_STATUS, 32'h18); check("R4 both keep 1", irq, 1);
    host_wr(W_STATUS, 32'h08); check("R4 lower", irq, 0);
    host_wr(W_STATUS, 32'h18); check("R4 both keep 0", irq, 0);
  endtask

  task automatic t_flags();
    logic [31:0] r;
    host_wr(W_STATUS, 32'h40);  check("R5 sstep set", sstep, 1);
    host_rd(W_STATUS, r);       check("R6 sstep bit5", r, 32'h21);
    host_wr(W_STATUS, 32'h100); check("R5 iob set", iob, 1);
    host_rd(W_STATUS, r);       check("R6 iob bit6", r, 32'h61);
    host_wr(W_STATUS, (32'h1 << 10) | (32'h1 << 16) | (32'h1 << 24));
    check("R5 signals 0,3,7", sig, 8'h89);
    host_rd(W_STATUS, r);       check("R6 signal bits", r, 32'h44E1);
    host_wr(W_STATUS, (32'h1 << 15) | (32'h1 << 16)); check("R5 sig3 both keep", sig, 8'h89);
    host_wr(W_STATUS, 32'h1 << 15); check("R5 sig3 clear", sig, 8'h81);
    host_wr(W_STATUS, 32'hA0);
    host_rd(W_STATUS, r);       check("R5 sstep iob clear", r, 32'h4081);
  endtask

  task automatic t_break();
    logic [31:0] r;
    host_wr(W_STATUS, 32'h100);
    host_wr(W_STATUS, 32'h1); check("R2 halt cleared", halt, 0);
    pulse_break(1'b0, 0);
    check("R11 halt", halt, 1); check("R11 broke", broke, 1); check("R11 irq", irq, 1);
    host_rd(W_STATUS, r); check("R6 after break", r, 32'h40C3);
    host_wr(W_STATUS, 32'h4); check("R3 clear broke", broke, 0);
    host_wr(W_STATUS, 32'h1555552);
    check("R3 set bits leave broke", broke, 0); check("R5 all signals", sig, 8'hFF);
    host_wr(W_STATUS, 32'hAAAAA8);
    check("R4 irq cleared", irq, 0); check("R5 signals cleared", sig, 0); check("R5 iob cleared", iob, 0);
    pulse_break(1'b0, 0);
    check("R11 no irq without iob", irq, 0); check("R11 broke again", broke, 1);
    host_wr(W_STATUS, 32'h4);
    host_wr(W_STATUS, 32'h1);
    pulse_break(1'b1, 32'h5);
    check("R11 break beats clear broke", broke, 1); check("R11 break beats clear halt", halt, 1);
    host_wr(W_STATUS, 32'h4);
  endtask

  task automatic t_pc();
    logic [31:0] r;
    host_wr(W_PC, 32'h1237);
    check("R8 pc_we halted", pc_we, 1); check("R8 pc data", pc_wdata, 12'h234);
    host_wr(W_STATUS, 32'h1);
    host_wr(W_PC, 32'h555); check("R8 pc_we blocked", pc_we, 0);
    pc = 12'hFFF; host_rd(W_PC, r); check("R9 pc read FFF", r, 32'hFFC);
    pc = 12'hA53; host_rd(W_PC, r); check("R9 pc read A53", r, 32'hA50);
  endtask

  task automatic t_misc();
    logic [31:0] r;
    busy = 1'b1; full = 1'b1;
    host_rd(W_FULL, r);   check("R10 full word", r, 1);
    host_rd(W_STATUS, r); check("R6 dma bits", r, 32'hC);
    host_rd(W_ZERO, r);   check("R10 zero word", r, 0);
    host_rd(4'd0, r);     check("R10 unmapped", r, 0);
    full = 1'b0;
    host_rd(W_FULL, r);   check("R10 full clear", r, 0);
    busy = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_sem();
    t_halt();
    t_intr();
    t_flags();
    t_break();
    t_pc();
    t_misc();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule